// File: doc/BRIEF.md
# Transmit Byte Queue with Interrupt Flags

This block sits between a host processor and the frame encoder of a reader transmitter. The host programs a 16-bit byte count, issues a transmit command to arm the block, and then streams frame bytes into a 24-entry queue. Sending starts when the first byte arrives in the queue, not when the command is issued. A drain engine passes one byte to the encoder for each request and counts down the bytes still to be sent.

Three events raise the interrupt line. The first is three bytes still to go, which tells the host to top up the queue. The second is the end of the frame. The third is the encoder asking for a byte while the queue is empty, which aborts the frame. The host reads a status register to see which event happened, and that read clears the flags.

The host can also send a short protocol command that needs no queued data. It then gets a start pulse and a command code straight away. A flush command clears the queue and stops any frame in progress.

Top module: `txfifo_irq_ctrl`

## Requirements
- R1: After reset, `irq`, `busy`, `enc_valid` and `fifo_level` are 0, and `host_rdata` is 0.
- R2: The byte count is written at address 0x1D (bits 7:0) and 0x1E (bits 15:8). Reading either address returns the stored byte on `host_rdata` in the cycle after the read strobe.
- R3: Each write to address 0x1F adds one byte to a 24-entry queue, shown on `fifo_level`. A write to a full queue is dropped.
- R4: `cmd_arm` loads the byte count and raises `busy`. No byte is offered to the encoder, and an encoder request has no effect, until the first queue write. Bytes then leave in write order, one per cycle in which `enc_valid` and `enc_ready` are both high. The byte on offer holds while it waits.
- R5: Status bit 0 (low-water) is set when a transfer leaves exactly 3 bytes still to send. A frame whose count is 3 or less never sets it.
- R6: Status bit 1 (done) is set when the last counted byte is transferred, and the block returns to idle. Arming with a count of 0 sets it at once and leaves the block idle.
- R7: Status bit 2 (underflow) is set if `enc_ready` is high in the sending phase while the queue is empty and bytes are still owed. The frame is then aborted and the queue emptied.
- R8: `irq` is high while any status bit is set. A read of address 0x0C returns the bits in positions 2:0 and clears them, and `irq` falls.
- R9: `cmd_direct` while idle gives a one-cycle `direct_start` in the next cycle, with the code on `direct_code_o`. While armed or sending, it is ignored.
- R10: `cmd_flush` empties the queue, returns the engine to idle and leaves the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| cmd_arm | input | 1 | Transmit command pulse |
| cmd_flush | input | 1 | Queue flush command pulse |
| cmd_direct | input | 1 | Direct protocol command pulse |
| direct_code | input | 4 | Code of the direct protocol command |
| enc_ready | input | 1 | Encoder requests a byte |
| enc_valid | output | 1 | A byte is on offer to the encoder |
| enc_data | output | 8 | Byte on offer |
| direct_start | output | 1 | One-cycle start of a direct command |
| direct_code_o | output | 4 | Code belonging to `direct_start` |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A frame is armed or being sent |
| fifo_level | output | 5 | Bytes held in the queue |

## Verification
The assertions assume the following about the inputs:
- Commands are single-cycle pulses.
- The host issues at most one register access per cycle.
- The encoder keeps `enc_ready` steady between clock edges.

The read-clear property counts only on a status read in a cycle where no new event arrives. The bench therefore changes every input on the falling edge and pulses each command for exactly one cycle. It reads status only once the engine is idle or held with `enc_ready` low, so no flag can be set in the same cycle as a read.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LEN_W  = 2 * BYTE_W;
  localparam int unsigned FLAG_W = 3;

  localparam logic [7:0] ADR_STATUS = 8'h0C;
  localparam logic [7:0] ADR_LEN_LO = 8'h1D;
  localparam logic [7:0] ADR_LEN_HI = 8'h1E;
  localparam logic [7:0] ADR_QUEUE  = 8'h1F;

  localparam int unsigned FL_LOW   = 0;
  localparam int unsigned FL_DONE  = 1;
  localparam int unsigned FL_UNDER = 2;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ARMED = 2'd1,
    ENG_SEND  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
  parameter int unsigned DEPTH = 24,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] level
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign level   = cnt_q;
  assign dout    = mem_q[rd_q];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_next(wr_q);
      if (do_pop)  rd_d = ptr_next(rd_q);
      cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage needs no reset: a slot is only read after it was written
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  p_full_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (cnt_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/txf_engine.sv
module txf_engine
  import txf_pkg::*;
#(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_arm,
  input  logic              cmd_flush,
  input  logic              cmd_direct,
  input  logic [CODE_W-1:0] direct_code,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              fifo_empty,
  input  logic              enc_ready,
  output logic              enc_valid,
  output logic              fifo_pop,
  output logic              abort_flush,
  output logic              set_low,
  output logic              set_done,
  output logic              set_under,
  output logic              busy,
  output logic              direct_start,
  output logic [CODE_W-1:0] direct_code_o
);
  eng_state_e        st_q, st_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              dst_q, dst_d;
  logic [CODE_W-1:0] dcode_q;

  assign enc_valid     = (st_q == ENG_SEND) && !fifo_empty;
  assign busy          = (st_q != ENG_IDLE);
  assign direct_start  = dst_q;
  assign direct_code_o = dcode_q;

  always_comb begin
    st_d        = st_q;
    rem_d       = rem_q;
    dst_d       = 1'b0;
    fifo_pop    = 1'b0;
    abort_flush = 1'b0;
    set_low     = 1'b0;
    set_done    = 1'b0;
    set_under   = 1'b0;
    if (cmd_flush) begin
      st_d  = ENG_IDLE;
      rem_d = '0;
    end else begin
      unique case (st_q)
        ENG_IDLE: begin
          if (cmd_arm) begin
            if (frame_len == '0) begin
              set_done = 1'b1;
            end else begin
              rem_d = frame_len;
              st_d  = ENG_ARMED;
            end
          end else if (cmd_direct) begin
            dst_d = 1'b1;
          end
        end
        ENG_ARMED: begin
          // first queued byte opens the frame
          if (!fifo_empty) st_d = ENG_SEND;
        end
        ENG_SEND: begin
          if (enc_ready) begin
            if (!fifo_empty) begin
              fifo_pop = 1'b1;
              rem_d    = rem_q - LEN_W'(1);
              if (rem_q == LEN_W'(4)) set_low = 1'b1;
              if (rem_q == LEN_W'(1)) begin
                set_done = 1'b1;
                st_d     = ENG_IDLE;
              end
            end else begin
              set_under   = 1'b1;
              abort_flush = 1'b1;
              st_d        = ENG_IDLE;
              rem_d       = '0;
            end
          end
        end
        default: begin
          st_d  = ENG_IDLE;
          rem_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      rem_q   <= '0;
      dst_q   <= 1'b0;
      dcode_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      dst_q <= dst_d;
      if (dst_d) dcode_q <= direct_code;
    end
  end

  p_send_owes_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_SEND) |-> (rem_q != '0));

  p_direct_from_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dst_q |-> ($past(cmd_direct) && $past(st_q) == ENG_IDLE));

  p_flush_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |=> (st_q == ENG_IDLE));

  p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_low && set_done, set_under && fifo_pop}) && !(set_low && set_done));
endmodule

// File: rtl/txf_regs.sv
module txf_regs
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [FLAG_W-1:0] set_flags,
  output logic [LEN_W-1:0]  frame_len,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              irq
);
  logic [LEN_W-1:0]  len_q, len_d;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [BYTE_W-1:0] rdata_q, rdata_d;
  logic              stat_rd;

  assign stat_rd    = host_rd && (host_addr == ADR_STATUS);
  assign frame_len  = len_q;
  assign host_rdata = rdata_q;
  assign irq        = |flags_q;

  always_comb begin
    len_d = len_q;
    if (host_wr && host_addr == ADR_LEN_LO) len_d[BYTE_W-1:0]     = host_wdata;
    if (host_wr && host_addr == ADR_LEN_HI) len_d[LEN_W-1:BYTE_W] = host_wdata;
    // an event arriving with the clearing read is kept
    flags_d = (stat_rd ? '0 : flags_q) | set_flags;
    rdata_d = rdata_q;
    if (host_rd) begin
      unique case (host_addr)
        ADR_STATUS: rdata_d = {{(BYTE_W-FLAG_W){1'b0}}, flags_q};
        ADR_LEN_LO: rdata_d = len_q[BYTE_W-1:0];
        ADR_LEN_HI: rdata_d = len_q[LEN_W-1:BYTE_W];
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      flags_q <= '0;
      rdata_q <= '0;
    end else begin
      len_q   <= len_d;
      flags_q <= flags_d;
      if (host_rd) rdata_q <= rdata_d;
    end
  end

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && set_flags == '0) |=> (flags_q == '0 && !irq));

  p_flags_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && irq) |=> irq);
endmodule

// File: rtl/txfifo_irq_ctrl.sv
module txfifo_irq_ctrl
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH  = 24,
  parameter int unsigned CODE_W = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              cmd_arm,
  input  logic              cmd_flush,
  input  logic              cmd_direct,
  input  logic [CODE_W-1:0] direct_code,
  input  logic              enc_ready,
  output logic              enc_valid,
  output logic [7:0]        enc_data,
  output logic              direct_start,
  output logic [CODE_W-1:0] direct_code_o,
  output logic              irq,
  output logic              busy,
  output logic [CNT_W-1:0]  fifo_level
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic [LEN_W-1:0]  frame_len;
  logic              q_empty, q_full, q_pop, q_push, abort_flush;
  logic              set_low, set_done, set_under;
  logic [FLAG_W-1:0] set_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign q_push = host_wr && (host_addr == ADR_QUEUE);

  always_comb begin
    set_flags           = '0;
    set_flags[FL_LOW]   = set_low;
    set_flags[FL_DONE]  = set_done;
    set_flags[FL_UNDER] = set_under;
  end

  txf_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .set_flags  (set_flags),
    .frame_len  (frame_len),
    .host_rdata (host_rdata),
    .irq        (irq)
  );

  txf_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_i_n),
    .flush (cmd_flush || abort_flush),
    .push  (q_push),
    .din   (host_wdata),
    .pop   (q_pop),
    .dout  (enc_data),
    .empty (q_empty),
    .full  (q_full),
    .level (fifo_level)
  );

  txf_engine #(.CODE_W(CODE_W)) u_engine (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .cmd_arm       (cmd_arm),
    .cmd_flush     (cmd_flush),
    .cmd_direct    (cmd_direct),
    .direct_code   (direct_code),
    .frame_len     (frame_len),
    .fifo_empty    (q_empty),
    .enc_ready     (enc_ready),
    .enc_valid     (enc_valid),
    .fifo_pop      (q_pop),
    .abort_flush   (abort_flush),
    .set_low       (set_low),
    .set_done      (set_done),
    .set_under     (set_under),
    .busy          (busy),
    .direct_start  (direct_start),
    .direct_code_o (direct_code_o)
  );

  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (enc_valid && !enc_ready && !cmd_flush) |=> (enc_valid && $stable(enc_data)));

  p_valid_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    enc_valid |-> (busy && !q_empty));

  p_full_flag_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    q_full |-> (fifo_level == CNT_W'(DEPTH)));
endmodule

// File: tb/txfifo_irq_ctrl_test.sv
module txfifo_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 0, host_rd = 0;
  logic [7:0] host_addr = 0, host_wdata = 0;
  logic [7:0] host_rdata;
  logic       cmd_arm = 0, cmd_flush = 0, cmd_direct = 0;
  logic [3:0] direct_code = 0;
  logic       enc_ready = 0;
  logic       enc_valid, direct_start, irq, busy;
  logic [7:0] enc_data;
  logic [3:0] direct_code_o;
  logic [4:0] fifo_level;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] cap [256];
  int cap_n = 0;

  always #2 clk = ~clk;

  txfifo_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_arm(cmd_arm), .cmd_flush(cmd_flush), .cmd_direct(cmd_direct),
    .direct_code(direct_code), .enc_ready(enc_ready), .enc_valid(enc_valid),
    .enc_data(enc_data), .direct_start(direct_start), .direct_code_o(direct_code_o),
    .irq(irq), .busy(busy), .fifo_level(fifo_level)
  );

  // record every accepted byte; inputs only move on falling edges
  always @(posedge clk) begin
    if (enc_valid && enc_ready && cap_n < 256) begin
      cap[cap_n] <= enc_data;
      cap_n <= cap_n + 1;
    end
  end

  // {count, bytes written, expected status}
  localparam logic [23:0] VECS [6] = '{
    {8'd5,  8'd5,  8'h03},
    {8'd3,  8'd3,  8'h02},
    {8'd24, 8'd24, 8'h03},
    {8'd6,  8'd4,  8'h05},
    {8'd1,  8'd1,  8'h02},
    {8'd24, 8'd26, 8'h03}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] v);
    host_addr = a; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    v = host_rdata;
  endtask

  task automatic set_len(input int n);
    host_write(8'h1D, 8'(n));
    host_write(8'h1E, 8'(n >> 8));
  endtask

  task automatic pulse_arm();
    cmd_arm = 1; @(negedge clk); cmd_arm = 0;
  endtask

  task automatic pulse_flush();
    cmd_flush = 1; @(negedge clk); cmd_flush = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run ended)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int base, bad, nsent;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 busy", busy, 0);
    check("R1 enc_valid", enc_valid, 0);
    check("R1 fifo_level", fifo_level, 0);
    check("R1 host_rdata", host_rdata, 0);

    // R2 count register readback
    host_write(8'h1D, 8'h34);
    host_write(8'h1E, 8'h12);
    host_read(8'h1D, v); check("R2 low byte", v, 8'h34);
    host_read(8'h1E, v); check("R2 high byte", v, 8'h12);

    // R4 armed frame waits for data even with encoder requesting
    set_len(2);
    pulse_arm();
    enc_ready = 1;
    repeat (5) @(negedge clk);
    check("R4 busy while armed", busy, 1);
    check("R4 no byte before write", enc_valid, 0);
    check("R4 no event before write", irq, 0);
    base = cap_n;
    host_write(8'h1F, 8'hA1);
    host_write(8'h1F, 8'hA2);
    wait_idle();
    enc_ready = 0;
    @(negedge clk);
    check("R4 sent count", cap_n - base, 2);
    check("R4 first byte", cap[base], 8'hA1);
    check("R4 second byte", cap[base+1], 8'hA2);
    check("R8 irq raised", irq, 1);
    host_read(8'h0C, v); check("R6 done only", v, 8'h02);
    check("R8 irq cleared", irq, 0);
    host_read(8'h0C, v); check("R8 status cleared", v, 0);

    // vector walk: R3 R5 R6 R7
    for (int k = 0; k < 6; k++) begin
      int len, nwr, expq;
      len = int'(VECS[k][23:16]);
      nwr = int'(VECS[k][15:8]);
      pulse_flush();
      set_len(len);
      pulse_arm();
      base = cap_n;
      for (int i = 0; i < nwr; i++) host_write(8'h1F, 8'(k * 40 + i));
      expq = (nwr > 24) ? 24 : nwr;
      check("R3 queue level", fifo_level, expq);
      enc_ready = 1;
      wait_idle();
      enc_ready = 0;
      @(negedge clk);
      nsent = (len < expq) ? len : expq;
      check("R4 bytes sent", cap_n - base, nsent);
      bad = 0;
      for (int i = 0; i < nsent; i++)
        if (cap[base+i] != 8'(k * 40 + i)) bad++;
      check("R4 byte order", bad, 0);
      host_read(8'h0C, v);
      check("R5 R6 R7 status", v, int'(VECS[k][7:0]));
      if (VECS[k][2]) check("R7 queue emptied", fifo_level, 0);
    end

    // R5 refill on low-water event, frame longer than the queue
    pulse_flush();
    set_len(26);
    pulse_arm();
    base = cap_n;
    for (int i = 0; i < 24; i++) host_write(8'h1F, 8'(100 + i));
    enc_ready = 1;
    for (int i = 0; i < 100 && !irq; i++) @(negedge clk);
    enc_ready = 0;
    check("R5 low-water after 23 sent", cap_n - base, 23);
    host_write(8'h1F, 8'(124));
    host_write(8'h1F, 8'(125));
    enc_ready = 1;
    wait_idle();
    enc_ready = 0;
    @(negedge clk);
    check("R5 refilled frame length", cap_n - base, 26);
    bad = 0;
    for (int i = 0; i < 26; i++) if (cap[base+i] != 8'(100 + i)) bad++;
    check("R5 refilled order", bad, 0);
    host_read(8'h0C, v); check("R5 low and done", v, 8'h03);

    // R6 zero count
    set_len(0);
    pulse_arm();
    check("R6 zero count idle", busy, 0);
    host_read(8'h0C, v); check("R6 zero count done", v, 8'h02);

    // R9 direct command from idle
    direct_code = 4'h5; cmd_direct = 1;
    @(negedge clk);
    cmd_direct = 0;
    check("R9 start pulse", direct_start, 1);
    check("R9 code", direct_code_o, 5);
    @(negedge clk);
    check("R9 pulse one cycle", direct_start, 0);

    // R9 ignored while armed; R10 flush
    set_len(4);
    pulse_arm();
    host_write(8'h1F, 8'h11);
    host_write(8'h1F, 8'h22);
    direct_code = 4'h9; cmd_direct = 1;
    @(negedge clk);
    cmd_direct = 0;
    check("R9 ignored while busy", direct_start, 0);
    check("R10 level before flush", fifo_level, 2);
    pulse_flush();
    check("R10 queue empty", fifo_level, 0);
    check("R10 engine idle", busy, 0);
    check("R10 no byte offered", enc_valid, 0);
    host_read(8'h0C, v); check("R10 flags untouched", v, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule